// File: doc/BRIEF.md
# Head-per-track disk word-transfer engine

This block moves 18-bit words between a head-per-track disk word store and main memory, with no processor involvement, one data break per word. The transfer length and the memory pointer are not held in the block. Software leaves them in two fixed low memory words: the count at octal 036 (30) and the pointer at octal 037 (31). For every word the engine reads each of these words, adds one and writes it back. The count is handled first, then the pointer. Only after that does the data word move.

A transfer begins with a one-cycle `start` pulse. That pulse carries a function code, a 22-bit starting disk address and a burst flag. Three configuration inputs stay steady for the whole transfer: a per-disk write-lock bitmap, the number of attached platters, and the highest installed memory address. The words can move back to back, or they can be spaced by a programmable idle interval. The block signals completion with a single-cycle `done` pulse. It also holds one sticky error flag for each of three causes: address beyond capacity, write-locked group, or write-check mismatch.

Top module: `drum_break_engine`

## Requirements
- R1: For each word the engine reads location 30, writes back that value plus one (modulo 2^18), then reads location 31 and writes back that value plus one. The incremented pointer is the memory address used for the word's data.
- R2: After a word completes, a word count of zero ends the transfer. `done` pulses for one cycle and `busy` is low in that same cycle. Software therefore loads the two's complement of the word count.
- R3: Function code 1 (read) copies the disk word at the current disk address into memory at the incremented pointer.
- R4: Function code 2 (write) copies the memory word at the incremented pointer into the disk store at the current disk address.
- R5: Function code 3 (write-check) compares the two words. On the first mismatch it sets `err_wce` and ends the transfer without advancing the disk address. When the words match, the transfer continues.
- R6: On a write, disk address bits 20:18 (disk) and 17:14 (group) select lock bit `wlock[disk*16+group]`. If that bit is set, `err_wlk` is raised and the transfer ends with no disk write. The count and pointer of that word have already been incremented.
- R7: Before any memory access of a word, the disk address is checked against the capacity (plat_m1+1)*2^18. A disk address at or above the capacity sets `err_nxd` and ends the transfer.
- R8: The disk address advances by exactly one after each word that completes without error.
- R9: With `burst` high the words follow back to back. With `burst` low, `gap` idle cycles are inserted before each later word, and a `gap` of zero counts as one cycle.
- R10: On a read, a word whose memory address is above `mem_last` is not written to memory. The count, the pointer and the disk address still advance.
- R11: After reset `busy`, `done`, all error flags and all memory and disk requests are low.
- R12: A `start` with function code 0 starts nothing and touches no memory.
- R13: At most one error flag is set at a time. All error flags clear at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a transfer |
| func | input | 2 | 0 none, 1 read, 2 write, 3 write-check |
| burst | input | 1 | 1: words back to back; 0: spaced by `gap` |
| gap | input | 16 | Idle cycles between words when not bursting |
| start_da | input | 22 | First disk word address |
| plat_m1 | input | 3 | Attached platters minus one |
| wlock | input | 128 | Lock bit per disk and track group |
| mem_last | input | 18 | Highest installed memory address |
| mem_req | output | 1 | Memory access request, one cycle per access |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 18 | Memory write data |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 18 | Memory read data |
| dsk_rd | output | 1 | Disk store read strobe |
| dsk_wr | output | 1 | Disk store write strobe |
| dsk_addr | output | 22 | Current disk address |
| dsk_wdata | output | 18 | Disk write data |
| dsk_rdata | input | 18 | Disk read data, one cycle after `dsk_rd` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err_nxd | output | 1 | Address beyond attached capacity |
| err_wlk | output | 1 | Write to a locked group |
| err_wce | output | 1 | Write-check mismatch |

## Verification
The checks inside the RTL assume a few things about the surroundings:
- Exactly one `mem_ack` arrives for each `mem_req` pulse, and no acknowledge arrives unasked.
- The disk store returns read data exactly one cycle after the strobe.
- `gap`, `plat_m1`, `wlock` and `mem_last` do not change while `busy` is high.

The bench keeps within these rules. Its memory and disk models answer with a fixed one-cycle latency, driven only by the engine's own strobes. It changes the configuration inputs only between transfers, after `done` has been seen.

// File: rtl/dbe_pkg.sv
package dbe_pkg;
   typedef enum logic [1:0] {
      FN_NONE = 2'd0,
      FN_RD   = 2'd1,
      FN_WR   = 2'd2,
      FN_WCHK = 2'd3
   } fn_e;

   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_CHK   = 4'd1,
      ST_WC_RD = 4'd2,
      ST_WC_WR = 4'd3,
      ST_CA_RD = 4'd4,
      ST_CA_WR = 4'd5,
      ST_DSK   = 4'd6,
      ST_MEM   = 4'd7,
      ST_DWR   = 4'd8,
      ST_NEXT  = 4'd9,
      ST_GAP   = 4'd10
   } step_e;
endpackage

// File: rtl/dbe_cap_check.sv
module dbe_cap_check #(
   parameter int unsigned HI_W      = 4,
   parameter int unsigned DISK_BITS = 3
) (
   input  logic [HI_W-1:0]      da_hi,
   input  logic [DISK_BITS-1:0] plat_m1,
   output logic                 over
);
   if (HI_W < DISK_BITS) begin : g_bad_width
      $error("dbe_cap_check: platter field wider than address");
   end

   // address >= (plat_m1+1)<<shift  <=>  upper address bits > plat_m1
   if (HI_W > DISK_BITS) begin : g_wide
      assign over = (da_hi > {{(HI_W-DISK_BITS){1'b0}}, plat_m1});
   end else begin : g_exact
      assign over = (da_hi > plat_m1);
   end
endmodule

// File: rtl/dbe_lock_sel.sv
module dbe_lock_sel #(
   parameter int unsigned DISK_BITS = 3,
   parameter int unsigned GRP_BITS  = 4
) (
   input  logic [DISK_BITS-1:0]                  disk_sel,
   input  logic [GRP_BITS-1:0]                   grp_sel,
   input  logic [(1<<(DISK_BITS+GRP_BITS))-1:0]  wlock,
   output logic                                  hit
);
   localparam int unsigned IDX_W = DISK_BITS + GRP_BITS;
   logic [IDX_W-1:0] idx;

   assign idx = {disk_sel, grp_sel};
   assign hit = wlock[idx];
endmodule

// File: rtl/dbe_gap_timer.sv
module dbe_gap_timer #(
   parameter int unsigned GAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [GAP_W-1:0] gap,
   output logic             expired
);
   if (GAP_W < 1) begin : g_bad_gap
      $error("dbe_gap_timer: GAP_W must be at least 1");
   end

   logic [GAP_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         // zero interval is taken as one cycle
         cnt <= (gap == '0) ? '0 : gap - 1'b1;
      end else if (run && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

   // R9
   gap_count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/drum_break_engine.sv
module drum_break_engine
   import dbe_pkg::*;
#(
   parameter int unsigned W         = 18,
   parameter int unsigned DA_W      = 22,
   parameter int unsigned DISK_BITS = 3,
   parameter int unsigned GRP_BITS  = 4,
   parameter int unsigned WPT_LOG   = 11,
   parameter int unsigned TPD_LOG   = 7,
   parameter int unsigned GAP_W     = 16,
   parameter int unsigned WC_LOC    = 30,
   parameter int unsigned CA_LOC    = 31
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  start,
   input  logic [1:0]                            func,
   input  logic                                  burst,
   input  logic [GAP_W-1:0]                      gap,
   input  logic [DA_W-1:0]                       start_da,
   input  logic [DISK_BITS-1:0]                  plat_m1,
   input  logic [(1<<(DISK_BITS+GRP_BITS))-1:0]  wlock,
   input  logic [W-1:0]                          mem_last,
   output logic                                  mem_req,
   output logic                                  mem_we,
   output logic [W-1:0]                          mem_addr,
   output logic [W-1:0]                          mem_wdata,
   input  logic                                  mem_ack,
   input  logic [W-1:0]                          mem_rdata,
   output logic                                  dsk_rd,
   output logic                                  dsk_wr,
   output logic [DA_W-1:0]                       dsk_addr,
   output logic [W-1:0]                          dsk_wdata,
   input  logic [W-1:0]                          dsk_rdata,
   output logic                                  busy,
   output logic                                  done,
   output logic                                  err_nxd,
   output logic                                  err_wlk,
   output logic                                  err_wce
);
   localparam int unsigned PLAT_SHIFT = WPT_LOG + TPD_LOG;
   localparam int unsigned HI_W       = DA_W - PLAT_SHIFT;

   if (PLAT_SHIFT + DISK_BITS > DA_W) begin : g_bad_da
      $error("drum_break_engine: disk address too narrow for disk field");
   end
   if (GRP_BITS > PLAT_SHIFT) begin : g_bad_grp
      $error("drum_break_engine: group field exceeds platter offset");
   end
   if (CA_LOC >= (1 << W) || WC_LOC >= (1 << W)) begin : g_bad_loc
      $error("drum_break_engine: pointer locations outside memory space");
   end

   step_e          step;
   fn_e            fn;
   logic           waiting;
   logic           burst_r;
   logic [W-1:0]   wc, ca, dbuf;
   logic [DA_W-1:0] da;
   logic           over, lock_hit, gap_done, gap_load, finish;

   dbe_cap_check #(.HI_W(HI_W), .DISK_BITS(DISK_BITS)) u_cap (
      .da_hi   (da[DA_W-1:PLAT_SHIFT]),
      .plat_m1 (plat_m1),
      .over    (over)
   );

   dbe_lock_sel #(.DISK_BITS(DISK_BITS), .GRP_BITS(GRP_BITS)) u_lock (
      .disk_sel (da[PLAT_SHIFT+DISK_BITS-1 -: DISK_BITS]),
      .grp_sel  (da[PLAT_SHIFT-1 -: GRP_BITS]),
      .wlock    (wlock),
      .hit      (lock_hit)
   );

   assign gap_load = (step == ST_NEXT) && !burst_r && (wc != '0);

   dbe_gap_timer #(.GAP_W(GAP_W)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (gap_load),
      .run     (step == ST_GAP),
      .gap     (gap),
      .expired (gap_done)
   );

   // memory and disk strobes
   always_comb begin
      mem_req   = !waiting && (step == ST_WC_RD || step == ST_WC_WR ||
                               step == ST_CA_RD || step == ST_CA_WR ||
                               step == ST_MEM);
      mem_we    = (step == ST_WC_WR) || (step == ST_CA_WR) ||
                  (step == ST_MEM && fn == FN_RD);
      if (step == ST_WC_RD || step == ST_WC_WR)      mem_addr = W'(WC_LOC);
      else if (step == ST_CA_RD || step == ST_CA_WR) mem_addr = W'(CA_LOC);
      else                                           mem_addr = ca;
      if (step == ST_WC_WR)      mem_wdata = wc;
      else if (step == ST_CA_WR) mem_wdata = ca;
      else                       mem_wdata = dbuf;
   end

   assign dsk_rd    = (step == ST_DSK) && !waiting;
   assign dsk_wr    = (step == ST_DWR);
   assign dsk_addr  = da;
   assign dsk_wdata = dbuf;
   assign busy      = (step != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step    <= ST_IDLE;
         fn      <= FN_NONE;
         waiting <= 1'b0;
         burst_r <= 1'b0;
         wc      <= '0;
         ca      <= '0;
         dbuf    <= '0;
         da      <= '0;
         done    <= 1'b0;
         err_nxd <= 1'b0;
         err_wlk <= 1'b0;
         err_wce <= 1'b0;
      end else begin
         done <= 1'b0;
         case (step)
            ST_IDLE: begin
               if (start && func != 2'd0) begin
                  fn      <= fn_e'(func);
                  burst_r <= burst;
                  da      <= start_da;
                  err_nxd <= 1'b0;
                  err_wlk <= 1'b0;
                  err_wce <= 1'b0;
                  step    <= ST_CHK;
               end
            end
            ST_CHK: begin
               if (over) begin
                  err_nxd <= 1'b1;
                  step    <= ST_IDLE;
                  done    <= 1'b1;
               end else begin
                  step <= ST_WC_RD;
               end
            end
            ST_WC_RD, ST_WC_WR, ST_CA_RD, ST_CA_WR, ST_MEM: begin
               if (!waiting) begin
                  waiting <= 1'b1;
               end else if (mem_ack) begin
                  waiting <= 1'b0;
                  case (step)
                     ST_WC_RD: begin
                        wc   <= mem_rdata + 1'b1;
                        step <= ST_WC_WR;
                     end
                     ST_WC_WR: step <= ST_CA_RD;
                     ST_CA_RD: begin
                        ca   <= mem_rdata + 1'b1;
                        step <= ST_CA_WR;
                     end
                     ST_CA_WR: begin
                        if (fn == FN_WR) begin
                           if (lock_hit) begin
                              err_wlk <= 1'b1;
                              step    <= ST_IDLE;
                              done    <= 1'b1;
                           end else begin
                              step <= ST_MEM;
                           end
                        end else begin
                           step <= ST_DSK;
                        end
                     end
                     default: begin
                        if (fn == FN_WR) begin
                           dbuf <= mem_rdata;
                           step <= ST_DWR;
                        end else if (fn == FN_WCHK && mem_rdata != dbuf) begin
                           err_wce <= 1'b1;
                           step    <= ST_IDLE;
                           done    <= 1'b1;
                        end else begin
                           step <= ST_NEXT;
                        end
                     end
                  endcase
               end
            end
            ST_DSK: begin
               if (!waiting) begin
                  waiting <= 1'b1;
               end else begin
                  waiting <= 1'b0;
                  dbuf    <= dsk_rdata;
                  if (fn == FN_RD && ca > mem_last) step <= ST_NEXT;
                  else                              step <= ST_MEM;
               end
            end
            ST_DWR: step <= ST_NEXT;
            ST_NEXT: begin
               da <= da + 1'b1;
               if (wc == '0) begin
                  step <= ST_IDLE;
                  done <= 1'b1;
               end else if (burst_r) begin
                  step <= ST_CHK;
               end else begin
                  step <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (gap_done) step <= ST_CHK;
            end
            default: step <= ST_IDLE;
         endcase
      end
   end

   assign finish = done;

   // R1
   ca_after_wc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_CA_RD && mem_req) |-> $past(step) == ST_WC_WR);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      finish |-> !busy);
   // R6
   no_locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsk_wr |-> !lock_hit);
   // R7
   dsk_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsk_rd || dsk_wr) |-> !over);
   // R8
   da_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == ST_NEXT) |=> da == $past(da) + 1'b1);
   // R9
   gap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap_load |=> step == ST_GAP);
   // R13
   one_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_nxd, err_wlk, err_wce}));
   // R11
   req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_req || dsk_rd || dsk_wr));
endmodule

// File: tb/tb_drum_break_engine.sv
module tb_drum_break_engine;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   func = 2'd0;
   logic         burst = 1'b1;
   logic [15:0]  gap = 16'd0;
   logic [21:0]  start_da = '0;
   logic [2:0]   plat_m1 = 3'd0;
   logic [127:0] wlock = '0;
   logic [17:0]  mem_last = 18'h3FFFF;
   logic         mem_req, mem_we, mem_ack;
   logic [17:0]  mem_addr, mem_wdata, mem_rdata;
   logic         dsk_rd, dsk_wr;
   logic [21:0]  dsk_addr;
   logic [17:0]  dsk_wdata, dsk_rdata;
   logic         busy, done, err_nxd, err_wlk, err_wce;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int t_first, t_second, n_rd;
   logic finished = 1'b0;

   logic [17:0] mem  [0:1023];
   logic [17:0] disk [0:4095];

   always #4 clk = ~clk;

   drum_break_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .func(func), .burst(burst),
      .gap(gap), .start_da(start_da), .plat_m1(plat_m1), .wlock(wlock),
      .mem_last(mem_last), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .dsk_rd(dsk_rd), .dsk_wr(dsk_wr),
      .dsk_addr(dsk_addr), .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata),
      .busy(busy), .done(done), .err_nxd(err_nxd), .err_wlk(err_wlk),
      .err_wce(err_wce)
   );

   // one-cycle memory and disk models
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req) begin
         mem_ack <= 1'b1;
         if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[9:0]];
      end
      if (dsk_rd) dsk_rdata <= disk[dsk_addr[11:0]];
      if (dsk_wr) disk[dsk_addr[11:0]] <= dsk_wdata;
   end

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] f, input logic b, input logic [15:0] g,
                         input logic [21:0] da, input int n, input logic [17:0] ca0);
      @(negedge clk);
      mem[30] = 18'(0 - n);
      mem[31] = ca0;
      func = f; burst = b; gap = g; start_da = da;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n_rd = 0; t_first = 0; t_second = 0;
      for (int k = 0; k < 5000; k++) begin
         if (dsk_rd) begin
            if (n_rd == 0) t_first = cyc;
            if (n_rd == 1) t_second = cyc;
            n_rd++;
         end
         if (done) break;
         @(negedge clk);
      end
      chk(done && !busy, "R2 done", {30'd0, done, busy}, 32'h2);
      @(negedge clk);
   endtask

   always @(negedge clk) cyc++;

   typedef struct packed {
      logic [1:0]  fn;
      logic        bst;
      logic [3:0]  gp;
      logic [21:0] da;
      logic [7:0]  n;
      logic [17:0] ca0;
   } vec_t;

   localparam vec_t VEC [0:5] = '{
      '{2'd1, 1'b1, 4'd0, 22'd16,  8'd4, 18'd100},
      '{2'd1, 1'b0, 4'd3, 22'd40,  8'd3, 18'd200},
      '{2'd2, 1'b1, 4'd0, 22'd60,  8'd5, 18'd300},
      '{2'd3, 1'b1, 4'd0, 22'd60,  8'd5, 18'd300},
      '{2'd2, 1'b0, 4'd0, 22'd80,  8'd2, 18'd400},
      '{2'd1, 1'b1, 4'd0, 22'd90,  8'd2, 18'h3FFFF}
   };

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 18'h10000 | 18'(i * 3);
      for (int i = 0; i < 4096; i++) disk[i] = 18'h20000 | 18'(i);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !done && !err_nxd && !err_wlk && !err_wce, "R11 reset flags",
          {27'd0, busy, done, err_nxd, err_wlk, err_wce}, 32'd0);
      chk(!mem_req && !dsk_rd && !dsk_wr, "R11 reset strobes",
          {29'd0, mem_req, dsk_rd, dsk_wr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector walk: R1 R3 R4 R5 R8
      for (int v = 0; v < 6; v++) begin
         run_op(VEC[v].fn, VEC[v].bst, 16'(VEC[v].gp), VEC[v].da, int'(VEC[v].n),
                VEC[v].ca0);
         for (int i = 0; i < int'(VEC[v].n); i++) begin
            logic [17:0] a;
            logic [11:0] d;
            a = VEC[v].ca0 + 18'd1 + 18'(i);
            d = 12'(VEC[v].da + 22'(i));
            if (VEC[v].fn == 2'd1)
               chk(mem[a[9:0]] == disk[d], "R3 read copy", 32'(mem[a[9:0]]), 32'(disk[d]));
            else if (VEC[v].fn == 2'd2)
               chk(disk[d] == mem[a[9:0]], "R4 write copy", 32'(disk[d]), 32'(mem[a[9:0]]));
         end
         chk(mem[30] == 18'd0, "R1 count wrapped", 32'(mem[30]), 32'd0);
         chk(mem[31] == VEC[v].ca0 + 18'(VEC[v].n), "R1 pointer final",
             32'(mem[31]), 32'(VEC[v].ca0 + 18'(VEC[v].n)));
         chk(dsk_addr == VEC[v].da + 22'(VEC[v].n), "R8 disk addr final",
             32'(dsk_addr), 32'(VEC[v].da + 22'(VEC[v].n)));
         chk(!err_nxd && !err_wlk && !err_wce, "R5 no error",
             {29'd0, err_nxd, err_wlk, err_wce}, 32'd0);
      end

      // R5 write-check mismatch on second word
      mem[302] = 18'h00777;
      run_op(2'd3, 1'b1, 16'd0, 22'd60, 5, 18'd300);
      chk(err_wce, "R5 mismatch flag", 32'(err_wce), 32'd1);
      chk(dsk_addr == 22'd61, "R5 addr held", 32'(dsk_addr), 32'd61);
      chk(mem[30] == 18'(0 - 3), "R5 count after two words", 32'(mem[30]), 32'(18'(0 - 3)));
      chk(mem[31] == 18'd302, "R5 pointer", 32'(mem[31]), 32'd302);

      // R6 write lock: disk 1 group 3 -> bit 19
      begin
         logic [17:0] keep;
         plat_m1 = 3'd1;
         wlock = '0;
         wlock[19] = 1'b1;
         keep = disk[0];
         run_op(2'd2, 1'b1, 16'd0, 22'h4C000, 2, 18'd600);
         chk(err_wlk, "R6 lock flag", 32'(err_wlk), 32'd1);
         chk(disk[0] == keep, "R6 no disk write", 32'(disk[0]), 32'(keep));
         chk(mem[30] == 18'(0 - 1), "R6 count incremented", 32'(mem[30]), 32'(18'(0 - 1)));
         chk(mem[31] == 18'd601, "R6 pointer incremented", 32'(mem[31]), 32'd601);
         chk(dsk_addr == 22'h4C000, "R6 addr held", 32'(dsk_addr), 32'h4C000);
         // R13 flags clear; neighbour group 2 unlocked
         run_op(2'd2, 1'b1, 16'd0, 22'h48000, 1, 18'd610);
         chk(!err_wlk && !err_nxd && !err_wce, "R13 flags cleared",
             {29'd0, err_nxd, err_wlk, err_wce}, 32'd0);
         chk(disk[0] == mem[611], "R6 unlocked group written", 32'(disk[0]), 32'(mem[611]));
         wlock = '0;
      end

      // R7 beyond capacity, nothing touched
      plat_m1 = 3'd0;
      run_op(2'd1, 1'b1, 16'd0, 22'h40000, 2, 18'd620);
      chk(err_nxd, "R7 nxd flag", 32'(err_nxd), 32'd1);
      chk(mem[30] == 18'(0 - 2), "R7 count untouched", 32'(mem[30]), 32'(18'(0 - 2)));
      chk(dsk_addr == 22'h40000, "R7 addr", 32'(dsk_addr), 32'h40000);

      // R7 boundary: last word fits, next does not
      run_op(2'd1, 1'b1, 16'd0, 22'h3FFFF, 2, 18'd630);
      chk(err_nxd, "R7 boundary flag", 32'(err_nxd), 32'd1);
      chk(mem[631] == disk[12'hFFF], "R7 last word read", 32'(mem[631]), 32'(disk[12'hFFF]));
      chk(mem[30] == 18'(0 - 1), "R7 one word counted", 32'(mem[30]), 32'(18'(0 - 1)));
      chk(dsk_addr == 22'h40000, "R8 boundary addr", 32'(dsk_addr), 32'h40000);

      // R10 skip above installed memory
      begin
         logic [17:0] k1, k2;
         mem_last = 18'd500;
         k1 = mem[501]; k2 = mem[502];
         run_op(2'd1, 1'b1, 16'd0, 22'd100, 3, 18'd499);
         chk(mem[500] == disk[100], "R10 in-range word", 32'(mem[500]), 32'(disk[100]));
         chk(mem[501] == k1 && mem[502] == k2, "R10 skipped words",
             32'(mem[501]), 32'(k1));
         chk(mem[31] == 18'd502, "R10 pointer advanced", 32'(mem[31]), 32'd502);
         chk(dsk_addr == 22'd103, "R10 addr advanced", 32'(dsk_addr), 32'd103);
         mem_last = 18'h3FFFF;
      end

      // R12 function 0 ignored
      begin
         logic [17:0] k;
         mem[30] = 18'h12345;
         k = mem[30];
         @(negedge clk);
         func = 2'd0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(!busy, "R12 not busy", 32'(busy), 32'd0);
         repeat (4) @(negedge clk);
         chk(mem[30] == k && !busy, "R12 memory untouched", 32'(mem[30]), 32'(k));
      end

      // R9 interword spacing
      begin
         int ib, i0, i5;
         run_op(2'd1, 1'b1, 16'd0, 22'd200, 2, 18'd700);
         ib = t_second - t_first;
         run_op(2'd1, 1'b0, 16'd0, 22'd200, 2, 18'd700);
         i0 = t_second - t_first;
         run_op(2'd1, 1'b0, 16'd5, 22'd200, 2, 18'd700);
         i5 = t_second - t_first;
         chk(i0 == ib + 1, "R9 zero gap is one", 32'(i0), 32'(ib + 1));
         chk(i5 == ib + 5, "R9 gap of five", 32'(i5), 32'(ib + 5));
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule